// File: doc/BRIEF.md
# Transmit Ring Slot Allocator

This block keeps the bookkeeping for a circular ring of transmit descriptors. A producer asks for a run of consecutive slots, one per fragment of a frame. If enough slots are free and the queue is running, the block grants the whole run in a single cycle and returns the first and last slot numbers. It also produces the tail value that the producer writes to the DMA engine. Completion logic hands slots back one at a time with a release strobe.

The occupancy count drives a queue-stop output with hysteresis. The stop asserts when a grant leaves fewer free slots than the low watermark. It deasserts only when releases bring the free count back to the higher resume watermark. Both watermarks are whole percentages of the ring size. The tail value is the slot that follows the frame's last slot, scaled to a byte offset by the descriptor size. Refused requests and releases on an empty ring are ignored and latch an error flag.

Top module: `txring_slot_alloc`

## Requirements
- R1: After reset, used_count is 0, free_count equals NUM_SLOTS, queue_stop, error_flag, grant and tail_wr are 0, and high_water is 0.
- R2: The first slot granted after reset is slot 0. Later grants continue in ring order from the last granted slot. The slot after NUM_SLOTS-1 is 0.
- R3: An accepted request for n slots appears one cycle later as a grant pulse with grant_last = grant_first + n - 1 (modulo NUM_SLOTS), and used_count rises by n. used_count + free_count always equals NUM_SLOTS.
- R4: A request is refused when req_frags is 0 or when req_frags exceeds free_count. A refused request gives no grant, leaves the counts unchanged and sets error_flag.
- R5: When an accepted request leaves free_count below SUSP_MARK = NUM_SLOTS*SUSP_PCT/100 (integer division), queue_stop asserts in the same cycle as the grant.
- R6: While queue_stop is 1, every request is refused (no grant) and sets error_flag.
- R7: Each accepted release lowers used_count by 1. queue_stop clears only on the release that brings free_count to at least RESUME_MARK = NUM_SLOTS*RESUME_PCT/100. Releases that leave free_count below that mark keep it set.
- R8: A release while used_count is 0 is ignored (used_count stays 0) and sets error_flag.
- R9: With each grant, tail_wr pulses and tail_index becomes ((grant_last+1) mod NUM_SLOTS) * D. D is 8 bytes when WIDE_DESC is 0 and 16 bytes when WIDE_DESC is 1.
- R10: high_water holds the largest used_count seen since reset.
- R11: error_flag stays set once set, until reset.
- R12: A request and a release in the same cycle are both applied, so used_count changes by n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request for a run of slots |
| req_frags | input | FRAG_W | Number of slots requested (1..MAX_FRAGS) |
| rel_valid | input | 1 | Return one slot |
| grant | output | 1 | One-cycle pulse: the last request was accepted |
| grant_first | output | SLOT_W | First slot of the granted run |
| grant_last | output | SLOT_W | Last slot of the granted run |
| tail_wr | output | 1 | Pulse: tail_index carries a new value |
| tail_index | output | TAIL_W | Byte offset of the slot after the last granted one |
| used_count | output | CNT_W | Slots in use |
| free_count | output | CNT_W | Slots free |
| queue_stop | output | 1 | Producer must hold new frames |
| high_water | output | CNT_W | Peak used_count since reset |
| error_flag | output | 1 | Sticky misuse indicator |

## Verification
On every cycle, the assertions check that the two counters stay consistent and bounded. They also check that high_water never falls below the current occupancy, that queue_stop changes state only at its watermarks, that nothing is granted while the queue is stopped, and that error_flag stays set. Only the bench scenarios can show the exact slot numbers and tail offsets across a ring wrap. They also show the full hysteresis window, from suspend through a run of releases to resume, and the refusal of an oversized request while the queue is running.

// File: rtl/txring_pkg.sv
package txring_pkg;

   localparam int NARROW_DESC_SHIFT = 3;
   localparam int WIDE_DESC_SHIFT   = 4;

   function automatic int pct_of(input int total, input int pct);
      return (total * pct) / 100;
   endfunction

   function automatic int width_of(input int value);
      return (value <= 1) ? 1 : $clog2(value);
   endfunction

endpackage

// File: rtl/txring_wrap_add.sv
module txring_wrap_add #(
   parameter int MODULUS = 16,
   parameter int A_W     = 4,
   parameter int B_W     = 4
) (
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   output logic [A_W-1:0] sum
);
   localparam int  WIDE_W  = (A_W > B_W ? A_W : B_W) + 1;
   localparam bit  IS_POW2 = ((MODULUS & (MODULUS - 1)) == 0) && ((1 << A_W) == MODULUS);

   generate
      if (IS_POW2) begin : g_pow2
         always_comb sum = a + A_W'(b);
      end else begin : g_cmp
         logic [WIDE_W-1:0] raw;
         logic [WIDE_W-1:0] folded;
         always_comb begin
            raw    = WIDE_W'(a) + WIDE_W'(b);
            folded = (raw >= WIDE_W'(MODULUS)) ? raw - WIDE_W'(MODULUS) : raw;
            sum    = folded[A_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/txring_occupancy.sv
module txring_occupancy #(
   parameter int NUM_SLOTS   = 16,
   parameter int SUSP_MARK   = 4,
   parameter int RESUME_MARK = 8,
   parameter int CNT_W       = 5,
   parameter int FRAG_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [FRAG_W-1:0] req_frags,
   input  logic              rel_valid,
   output logic              grant_ok,
   output logic [CNT_W-1:0]  used_count,
   output logic [CNT_W-1:0]  free_count,
   output logic              queue_stop,
   output logic [CNT_W-1:0]  high_water,
   output logic              error_flag
);
   localparam logic [CNT_W-1:0] SLOTS_C  = CNT_W'(NUM_SLOTS);
   localparam logic [CNT_W-1:0] SUSP_C   = CNT_W'(SUSP_MARK);
   localparam logic [CNT_W-1:0] RESUME_C = CNT_W'(RESUME_MARK);

   logic [CNT_W-1:0] used_q, free_q, peak_q;
   logic             stop_q, err_q;
   logic [CNT_W-1:0] frags_ext, take, give;
   logic [CNT_W-1:0] used_nxt, free_nxt;
   logic             rel_ok, stop_nxt;

   always_comb begin
      frags_ext = CNT_W'(req_frags);
      grant_ok  = req_valid && !stop_q && (req_frags != '0) && (frags_ext <= free_q);
      rel_ok    = rel_valid && (used_q != '0);
      take      = grant_ok ? frags_ext : '0;
      give      = rel_ok ? CNT_W'(1) : '0;
      used_nxt  = used_q + take - give;
      free_nxt  = free_q - take + give;
      if (stop_q)
         stop_nxt = !(rel_ok && (free_nxt >= RESUME_C));
      else
         stop_nxt = grant_ok && (free_nxt < SUSP_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
         free_q <= SLOTS_C;
         peak_q <= '0;
         stop_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         used_q <= used_nxt;
         free_q <= free_nxt;
         stop_q <= stop_nxt;
         if (used_nxt > peak_q)
            peak_q <= used_nxt;
         if ((req_valid && !grant_ok) || (rel_valid && !rel_ok))
            err_q <= 1'b1;
      end
   end

   assign used_count = used_q;
   assign free_count = free_q;
   assign queue_stop = stop_q;
   assign high_water = peak_q;
   assign error_flag = err_q;

   AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W+1)'(used_q) + (CNT_W+1)'(free_q) == (CNT_W+1)'(NUM_SLOTS)); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= SLOTS_C); // R3
   AST_STOP_AT_LOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_q) |-> (free_q < SUSP_C)); // R5
   AST_RESUME_AT_HIGH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_q) |-> (free_q >= RESUME_C)); // R7
   AST_PEAK_COVERS_USED: assert property (@(posedge clk) disable iff (!rst_n)
      peak_q >= used_q); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R11
   AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !req_valid && used_q == '0) |=> (used_q == '0)); // R8

endmodule

// File: rtl/txring_tail.sv
module txring_tail #(
   parameter int NUM_SLOTS = 16,
   parameter int SLOT_W    = 4,
   parameter int FRAG_W    = 4,
   parameter bit WIDE_DESC = 1'b0,
   parameter int TAIL_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_ok,
   input  logic [FRAG_W-1:0] req_frags,
   output logic              grant,
   output logic [SLOT_W-1:0] grant_first,
   output logic [SLOT_W-1:0] grant_last,
   output logic [TAIL_W-1:0] tail_index
);
   import txring_pkg::*;

   localparam int DESC_SHIFT = WIDE_DESC ? WIDE_DESC_SHIFT : NARROW_DESC_SHIFT;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   logic [SLOT_W-1:0] cur_q;
   logic [SLOT_W-1:0] first_c, last_c, after_c;
   logic [TAIL_W-1:0] tail_c;
   logic              grant_q;
   logic [SLOT_W-1:0] first_q, last_q;
   logic [TAIL_W-1:0] tail_q;

   txring_wrap_add #(.MODULUS(NUM_SLOTS), .A_W(SLOT_W), .B_W(1)) u_first (
      .a(cur_q), .b(1'b1), .sum(first_c));
   txring_wrap_add #(.MODULUS(NUM_SLOTS), .A_W(SLOT_W), .B_W(FRAG_W)) u_last (
      .a(cur_q), .b(req_frags), .sum(last_c));
   txring_wrap_add #(.MODULUS(NUM_SLOTS), .A_W(SLOT_W), .B_W(1)) u_after (
      .a(last_c), .b(1'b1), .sum(after_c));

   generate
      if (WIDE_DESC) begin : g_wide
         always_comb tail_c = {after_c, {WIDE_DESC_SHIFT{1'b0}}};
      end else begin : g_narrow
         always_comb tail_c = {after_c, {NARROW_DESC_SHIFT{1'b0}}};
      end
      if (TAIL_W != SLOT_W + DESC_SHIFT) begin : g_bad_tail
         $error("TAIL_W must equal SLOT_W plus the descriptor shift");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= LAST_SLOT;
         grant_q <= 1'b0;
         first_q <= '0;
         last_q  <= '0;
         tail_q  <= '0;
      end else begin
         grant_q <= grant_ok;
         if (grant_ok) begin
            cur_q   <= last_c;
            first_q <= first_c;
            last_q  <= last_c;
            tail_q  <= tail_c;
         end
      end
   end

   assign grant       = grant_q;
   assign grant_first = first_q;
   assign grant_last  = last_q;
   assign tail_index  = tail_q;

   AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      grant_ok |=> (grant_first == first_c_prev)); // R2
   logic [SLOT_W-1:0] first_c_prev;
   always_ff @(posedge clk) first_c_prev <= first_c;
   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_first <= LAST_SLOT) && (grant_last <= LAST_SLOT)); // R2

endmodule

// File: rtl/txring_slot_alloc.sv
module txring_slot_alloc #(
   parameter int NUM_SLOTS  = 16,
   parameter int MAX_FRAGS  = 8,
   parameter int SUSP_PCT   = 25,
   parameter int RESUME_PCT = 50,
   parameter bit WIDE_DESC  = 1'b0,
   parameter int SLOT_W     = txring_pkg::width_of(NUM_SLOTS),
   parameter int CNT_W      = $clog2(NUM_SLOTS + 1),
   parameter int FRAG_W     = $clog2(MAX_FRAGS + 1),
   parameter int TAIL_W     = SLOT_W + (WIDE_DESC ? txring_pkg::WIDE_DESC_SHIFT
                                                  : txring_pkg::NARROW_DESC_SHIFT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [FRAG_W-1:0] req_frags,
   input  logic              rel_valid,
   output logic              grant,
   output logic [SLOT_W-1:0] grant_first,
   output logic [SLOT_W-1:0] grant_last,
   output logic              tail_wr,
   output logic [TAIL_W-1:0] tail_index,
   output logic [CNT_W-1:0]  used_count,
   output logic [CNT_W-1:0]  free_count,
   output logic              queue_stop,
   output logic [CNT_W-1:0]  high_water,
   output logic              error_flag
);
   import txring_pkg::*;

   localparam int SUSP_MARK   = pct_of(NUM_SLOTS, SUSP_PCT);
   localparam int RESUME_MARK = pct_of(NUM_SLOTS, RESUME_PCT);

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 2");
      end
      if (MAX_FRAGS < 1 || MAX_FRAGS > NUM_SLOTS) begin : g_bad_frags
         $error("MAX_FRAGS must lie in 1..NUM_SLOTS");
      end
      if (SUSP_MARK >= RESUME_MARK) begin : g_bad_marks
         $error("suspend watermark must be below resume watermark");
      end
      if (RESUME_MARK > NUM_SLOTS) begin : g_bad_resume
         $error("resume watermark exceeds ring size");
      end
   endgenerate

   logic grant_ok;
   logic grant_pulse;

   txring_occupancy #(
      .NUM_SLOTS(NUM_SLOTS), .SUSP_MARK(SUSP_MARK), .RESUME_MARK(RESUME_MARK),
      .CNT_W(CNT_W), .FRAG_W(FRAG_W)
   ) u_occ (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_frags(req_frags), .rel_valid(rel_valid),
      .grant_ok(grant_ok),
      .used_count(used_count), .free_count(free_count),
      .queue_stop(queue_stop), .high_water(high_water), .error_flag(error_flag)
   );

   txring_tail #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .FRAG_W(FRAG_W),
      .WIDE_DESC(WIDE_DESC), .TAIL_W(TAIL_W)
   ) u_tail (
      .clk(clk), .rst_n(rst_n),
      .grant_ok(grant_ok), .req_frags(req_frags),
      .grant(grant_pulse), .grant_first(grant_first), .grant_last(grant_last),
      .tail_index(tail_index)
   );

   assign grant   = grant_pulse;
   assign tail_wr = grant_pulse;

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (grant == $past(grant_ok))); // R4
   AST_NO_GRANT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && queue_stop) |=> !grant); // R6
   AST_ZERO_FRAGS_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_frags == '0) |=> (!grant && error_flag)); // R4

endmodule

// File: tb/txring_slot_alloc_bench.sv
`timescale 1ns/1ps
module txring_slot_alloc_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [3:0] req_frags = '0;
   logic       rel_valid = 1'b0;
   logic       grant, tail_wr, queue_stop, error_flag;
   logic [3:0] grant_first, grant_last;
   logic [6:0] tail_index;
   logic [4:0] used_count, free_count, high_water;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   txring_slot_alloc u_txring_slot_alloc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_frags(req_frags),
      .rel_valid(rel_valid), .grant(grant), .grant_first(grant_first),
      .grant_last(grant_last), .tail_wr(tail_wr), .tail_index(tail_index),
      .used_count(used_count), .free_count(free_count), .queue_stop(queue_stop),
      .high_water(high_water), .error_flag(error_flag));

   typedef struct packed {
      logic       req;
      logic [3:0] frags;
      logic       rel;
      logic       grant;
      logic [3:0] first;
      logic [3:0] last;
      logic [4:0] used;
      logic       stop;
      logic       err;
      logic [6:0] tail;
   } vec_t;

   // 16 slots, watermarks 4 and 8, 8-byte descriptors
   localparam vec_t VECS [15] = '{
      '{1'b1, 4'd1, 1'b0, 1'b1, 4'd0,  4'd0,  5'd1,  1'b0, 1'b0, 7'd8},
      '{1'b1, 4'd3, 1'b0, 1'b1, 4'd1,  4'd3,  5'd4,  1'b0, 1'b0, 7'd32},
      '{1'b1, 4'd4, 1'b0, 1'b1, 4'd4,  4'd7,  5'd8,  1'b0, 1'b0, 7'd64},
      '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  4'd0,  5'd7,  1'b0, 1'b0, 7'd0},
      '{1'b1, 4'd4, 1'b0, 1'b1, 4'd8,  4'd11, 5'd11, 1'b0, 1'b0, 7'd96},
      '{1'b1, 4'd2, 1'b0, 1'b1, 4'd12, 4'd13, 5'd13, 1'b1, 1'b0, 7'd112},
      '{1'b1, 4'd1, 1'b0, 1'b0, 4'd0,  4'd0,  5'd13, 1'b1, 1'b1, 7'd0},
      '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  4'd0,  5'd12, 1'b1, 1'b1, 7'd0},
      '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  4'd0,  5'd11, 1'b1, 1'b1, 7'd0},
      '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  4'd0,  5'd10, 1'b1, 1'b1, 7'd0},
      '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  4'd0,  5'd9,  1'b1, 1'b1, 7'd0},
      '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  4'd0,  5'd8,  1'b0, 1'b1, 7'd0},
      '{1'b1, 4'd4, 1'b0, 1'b1, 4'd14, 4'd1,  5'd12, 1'b0, 1'b1, 7'd16},
      '{1'b1, 4'd1, 1'b1, 1'b1, 4'd2,  4'd2,  5'd12, 1'b0, 1'b1, 7'd24},
      '{1'b1, 4'd4, 1'b0, 1'b1, 4'd3,  4'd6,  5'd16, 1'b1, 1'b1, 7'd56}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input logic rq, input logic [3:0] nf, input logic rl);
      @(negedge clk);
      req_valid = rq;
      req_frags = nf;
      rel_valid = rl;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      req_frags = '0;
      rel_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", "used", int'(used_count), 0);
      chk("R1", "free", int'(free_count), 16);
      chk("R1", "stop", int'(queue_stop), 0);
      chk("R1", "err", int'(error_flag), 0);
      chk("R1", "grant", int'(grant), 0);
      chk("R1", "tail_wr", int'(tail_wr), 0);
      chk("R1", "high", int'(high_water), 0);

      // R2 R3 R5 R6 R7 R9 R11 R12 table walk
      foreach (VECS[i]) begin
         step(VECS[i].req, VECS[i].frags, VECS[i].rel);
         chk("R3", $sformatf("v%0d grant", i), int'(grant), int'(VECS[i].grant));
         chk("R9", $sformatf("v%0d tail_wr", i), int'(tail_wr), int'(VECS[i].grant));
         if (VECS[i].grant) begin
            chk("R2", $sformatf("v%0d first", i), int'(grant_first), int'(VECS[i].first));
            chk("R3", $sformatf("v%0d last", i), int'(grant_last), int'(VECS[i].last));
            chk("R9", $sformatf("v%0d tail", i), int'(tail_index), int'(VECS[i].tail));
         end
         chk("R7", $sformatf("v%0d used", i), int'(used_count), int'(VECS[i].used));
         chk("R3", $sformatf("v%0d free", i), int'(free_count), 16 - int'(VECS[i].used));
         chk("R5", $sformatf("v%0d stop", i), int'(queue_stop), int'(VECS[i].stop));
         chk("R11", $sformatf("v%0d err", i), int'(error_flag), int'(VECS[i].err));
      end
      // R10 peak after full ring
      chk("R10", "high", int'(high_water), 16);
      // R6 request at full, stopped ring
      step(1'b1, 4'd1, 1'b0);
      chk("R6", "grant", int'(grant), 0);
      chk("R6", "used", int'(used_count), 16);

      // R8 release on empty ring
      do_reset();
      step(1'b0, 4'd0, 1'b1);
      chk("R8", "used", int'(used_count), 0);
      chk("R8", "free", int'(free_count), 16);
      chk("R8", "err", int'(error_flag), 1);

      // R4 zero-length request
      do_reset();
      step(1'b1, 4'd0, 1'b0);
      chk("R4", "zero grant", int'(grant), 0);
      chk("R4", "zero used", int'(used_count), 0);
      chk("R4", "zero err", int'(error_flag), 1);

      // R4 oversize request while queue runs
      do_reset();
      step(1'b1, 4'd8, 1'b0);
      chk("R2", "restart first", int'(grant_first), 0);
      chk("R3", "run last", int'(grant_last), 7);
      step(1'b1, 4'd4, 1'b0);
      chk("R3", "used12", int'(used_count), 12);
      chk("R5", "no stop at mark", int'(queue_stop), 0);
      step(1'b1, 4'd5, 1'b0);
      chk("R4", "big grant", int'(grant), 0);
      chk("R4", "big used", int'(used_count), 12);
      chk("R4", "big err", int'(error_flag), 1);
      chk("R4", "big stop", int'(queue_stop), 0);
      chk("R9", "tail held", int'(tail_index), 96);
      step(1'b1, 4'd4, 1'b0);
      chk("R2", "after refuse first", int'(grant_first), 12);
      chk("R9", "wrap tail", int'(tail_index), 0);
      chk("R5", "stop at empty", int'(queue_stop), 1);

      finish_run();
   end
endmodule